// File: doc/BRIEF.md
# Hypervisor Trap Decision Logic

This block decides, for one operation presented by the pipeline, whether that operation must be trapped to the hypervisor level (EL2). For a synchronous external abort, it decides instead whether the abort is routed up to EL2 or to EL3. The pipeline supplies the following on a one-cycle strobe:

- the operation class;
- the current exception level;
- the security state;
- the six hypervisor trap/route controls;
- the two host-mode bits (E2H, TGE);
- an EL3 abort-route indication.

One clock later the block returns a registered verdict: a trap flag, the exception class syndrome to report, and two mutually exclusive abort-routing flags.

The block holds no architectural state of its own. The control register bits are inputs, and the block only qualifies them. When E2H and TGE are both 1, the four instruction-trap controls for TLB, cache and ID maintenance are treated as zero for the decision. The control bits themselves are not altered. The error-record trap and the abort-route control are not affected by host mode. Taking the exception and performing the maintenance operation are left to the surrounding logic.

Top module: `hyp_trap_decider`

## Requirements
- R1: While reset is held, and in every cycle whose previous clock edge saw no `req_valid`, all outputs are 0. `rsp_valid` is 1 exactly one cycle after a cycle with `req_valid` = 1.
- R2: For operation class 1 (inner-shareable TLB maintenance), `rsp_trap_el2` is 1 only when all of these hold: `ctl_tlbis` = 1, non-secure, and EL = 1.
- R3: For operation class 2 (cache maintenance to the point of unification), `rsp_trap_el2` is 1 only when all of these hold: `ctl_pou` = 1, non-secure, and EL is 0 or 1.
- R4: For operation class 3 (inner-shareable invalidate-all of the instruction cache), `rsp_trap_el2` is 1 only when all of these hold: `ctl_icab` = 1, non-secure, and EL = 1.
- R5: For operation class 4 (ID group 4 register read), `rsp_trap_el2` is 1 only when all of these hold: `ctl_idg4` = 1, non-secure, and EL is 0 or 1.
- R6: When `mode_e2h` = `mode_tge` = 1, classes 1 to 4 never trap, whatever their controls. Classes 5, 6 and 7 are decided as if host mode were off.
- R7: For class 5 (single-register error-record access) and class 6 (two-register error-record access), `rsp_trap_el2` is 1 only when all of these hold: `ctl_errrec` = 1, non-secure, and EL = 1. A trap reports `rsp_syndrome` 0x03 for classes 1 to 5 and 0x04 for class 6. `rsp_syndrome` is 0 whenever `rsp_trap_el2` is 0.
- R8: For class 7 (synchronous external abort), `rsp_trap_el2` stays 0.
  - If `el3_abort_route` = 1, then `rsp_abort_el3` = 1 and `rsp_abort_el2` = 0.
  - Otherwise `rsp_abort_el2` = 1 only when all of these hold: `ctl_abort_route` = 1, non-secure, and EL is 0 or 1.
  - At most one routing output is ever 1, and neither is 1 for classes other than 7.
- R9: Class 0, secure-state operations, and operations at EL2 or EL3 never raise `rsp_trap_el2`. A class whose control is 0 never raises it either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Strobe: an operation is presented this cycle |
| req_op | input | 3 | Operation class, 0 to 7 as in the requirements |
| req_el | input | 2 | Current exception level, 0 to 3 |
| req_nonsecure | input | 1 | 1 = non-secure state |
| ctl_tlbis | input | 1 | Trap control for inner-shareable TLB maintenance |
| ctl_pou | input | 1 | Trap control for point-of-unification cache maintenance |
| ctl_icab | input | 1 | Trap control for inner-shareable instruction-cache invalidate-all |
| ctl_idg4 | input | 1 | Trap control for ID group 4 reads |
| ctl_errrec | input | 1 | Trap control for error-record accesses |
| ctl_abort_route | input | 1 | Route synchronous external aborts to EL2 |
| mode_e2h | input | 1 | Host-mode bit E2H |
| mode_tge | input | 1 | Host-mode bit TGE |
| el3_abort_route | input | 1 | The abort is already routed to EL3 |
| rsp_valid | output | 1 | Verdict valid, one cycle after the strobe |
| rsp_trap_el2 | output | 1 | Trap the operation to EL2 |
| rsp_syndrome | output | 6 | Exception class syndrome of the trap |
| rsp_abort_el2 | output | 1 | Route the abort to EL2 |
| rsp_abort_el3 | output | 1 | Route the abort to EL3 |

## Verification
Two decisions can meet on the same abort event: the EL3 route and the EL2 abort-route control. The bench drives both as 1 on class-7 events from non-secure EL0/EL1, and expects only the EL3 flag. A second collision comes from host mode together with every trap control set. Under that setting, classes 1 to 4 must come back silent, while error-record accesses in the same run must still trap with the single or dual syndrome. Random stimulus, which favours set controls, produces both mixes many times, and every verdict is compared with a reference function written in the bench.

// File: rtl/hyp_trap_pkg.sv
`timescale 1ns/1ps
package hyp_trap_pkg;

  localparam int OP_W = 3;
  localparam int EL_W = 2;
  localparam int EC_W = 6;

  typedef enum logic [OP_W-1:0] {
    OP_NONE       = 3'd0,
    OP_TLBI_IS    = 3'd1,
    OP_POU_CMO    = 3'd2,
    OP_ICALL_IS   = 3'd3,
    OP_IDG4_READ  = 3'd4,
    OP_ERR_SINGLE = 3'd5,
    OP_ERR_DUAL   = 3'd6,
    OP_SYNC_ABORT = 3'd7
  } op_class_e;

  localparam logic [EC_W-1:0] EC_NONE   = '0;
  localparam logic [EC_W-1:0] EC_SINGLE = 6'h03;
  localparam logic [EC_W-1:0] EC_DUAL   = 6'h04;

  // EL0 or EL1
  function automatic logic is_guest_el(input logic [EL_W-1:0] el);
    return el <= EL_W'(1);
  endfunction

  function automatic logic is_el1(input logic [EL_W-1:0] el);
    return el == EL_W'(1);
  endfunction

  // host mode: E2H and TGE both set
  function automatic logic host_mode(input logic e2h, input logic tge);
    return e2h & tge;
  endfunction

  function automatic logic [EC_W-1:0] syndrome_for(input op_class_e op);
    return (op == OP_ERR_DUAL) ? EC_DUAL : EC_SINGLE;
  endfunction

endpackage

// File: rtl/hyp_ctl_mask.sv
`timescale 1ns/1ps
module hyp_ctl_mask (
  input  logic ctl_tlbis,
  input  logic ctl_pou,
  input  logic ctl_icab,
  input  logic ctl_idg4,
  input  logic mode_e2h,
  input  logic mode_tge,
  output logic eff_tlbis,
  output logic eff_pou,
  output logic eff_icab,
  output logic eff_idg4
);
  import hyp_trap_pkg::*;

  logic in_host;

  always_comb begin
    in_host   = host_mode(mode_e2h, mode_tge);
    eff_tlbis = ctl_tlbis & ~in_host;
    eff_pou   = ctl_pou   & ~in_host;
    eff_icab  = ctl_icab  & ~in_host;
    eff_idg4  = ctl_idg4  & ~in_host;
  end

endmodule

// File: rtl/hyp_trap_select.sv
`timescale 1ns/1ps
module hyp_trap_select
  import hyp_trap_pkg::*;
(
  input  op_class_e             op,
  input  logic [EL_W-1:0]       el,
  input  logic                  nonsecure,
  input  logic                  eff_tlbis,
  input  logic                  eff_pou,
  input  logic                  eff_icab,
  input  logic                  eff_idg4,
  input  logic                  ctl_errrec,
  output logic                  trap,
  output logic [EC_W-1:0]       syndrome
);

  logic at_el1;
  logic at_guest;

  always_comb begin
    at_el1   = nonsecure & is_el1(el);
    at_guest = nonsecure & is_guest_el(el);
    unique case (op)
      OP_TLBI_IS:    trap = eff_tlbis  & at_el1;
      OP_POU_CMO:    trap = eff_pou    & at_guest;
      OP_ICALL_IS:   trap = eff_icab   & at_el1;
      OP_IDG4_READ:  trap = eff_idg4   & at_guest;
      OP_ERR_SINGLE,
      OP_ERR_DUAL:   trap = ctl_errrec & at_el1;
      default:       trap = 1'b0;
    endcase
    syndrome = trap ? syndrome_for(op) : EC_NONE;
  end

endmodule

// File: rtl/hyp_abort_router.sv
`timescale 1ns/1ps
module hyp_abort_router
  import hyp_trap_pkg::*;
(
  input  op_class_e       op,
  input  logic [EL_W-1:0] el,
  input  logic            nonsecure,
  input  logic            ctl_abort_route,
  input  logic            el3_abort_route,
  output logic            to_el2,
  output logic            to_el3
);

  logic is_abort;

  always_comb begin
    is_abort = (op == OP_SYNC_ABORT);
    to_el3   = is_abort & el3_abort_route;
    to_el2   = is_abort & ~el3_abort_route & ctl_abort_route
             & nonsecure & is_guest_el(el);
  end

endmodule

// File: rtl/hyp_trap_decider.sv
`timescale 1ns/1ps
module hyp_trap_decider
  import hyp_trap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [OP_W-1:0]  req_op,
  input  logic [EL_W-1:0]  req_el,
  input  logic             req_nonsecure,
  input  logic             ctl_tlbis,
  input  logic             ctl_pou,
  input  logic             ctl_icab,
  input  logic             ctl_idg4,
  input  logic             ctl_errrec,
  input  logic             ctl_abort_route,
  input  logic             mode_e2h,
  input  logic             mode_tge,
  input  logic             el3_abort_route,
  output logic             rsp_valid,
  output logic             rsp_trap_el2,
  output logic [EC_W-1:0]  rsp_syndrome,
  output logic             rsp_abort_el2,
  output logic             rsp_abort_el3
);

  op_class_e       op_cls;
  logic            eff_tlbis, eff_pou, eff_icab, eff_idg4;
  logic            nxt_trap;
  logic [EC_W-1:0] nxt_syndrome;
  logic            nxt_abort_el2, nxt_abort_el3;

  assign op_cls = op_class_e'(req_op);

  hyp_ctl_mask u_mask (
    .ctl_tlbis (ctl_tlbis),
    .ctl_pou   (ctl_pou),
    .ctl_icab  (ctl_icab),
    .ctl_idg4  (ctl_idg4),
    .mode_e2h  (mode_e2h),
    .mode_tge  (mode_tge),
    .eff_tlbis (eff_tlbis),
    .eff_pou   (eff_pou),
    .eff_icab  (eff_icab),
    .eff_idg4  (eff_idg4)
  );

  hyp_trap_select u_select (
    .op         (op_cls),
    .el         (req_el),
    .nonsecure  (req_nonsecure),
    .eff_tlbis  (eff_tlbis),
    .eff_pou    (eff_pou),
    .eff_icab   (eff_icab),
    .eff_idg4   (eff_idg4),
    .ctl_errrec (ctl_errrec),
    .trap       (nxt_trap),
    .syndrome   (nxt_syndrome)
  );

  hyp_abort_router u_router (
    .op              (op_cls),
    .el              (req_el),
    .nonsecure       (req_nonsecure),
    .ctl_abort_route (ctl_abort_route),
    .el3_abort_route (el3_abort_route),
    .to_el2          (nxt_abort_el2),
    .to_el3          (nxt_abort_el3)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_trap_el2  <= 1'b0;
      rsp_syndrome  <= EC_NONE;
      rsp_abort_el2 <= 1'b0;
      rsp_abort_el3 <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_trap_el2  <= req_valid & nxt_trap;
      rsp_syndrome  <= req_valid ? nxt_syndrome : EC_NONE;
      rsp_abort_el2 <= req_valid & nxt_abort_el2;
      rsp_abort_el3 <= req_valid & nxt_abort_el3;
    end
  end

endmodule

// File: rtl/hyp_trap_checker.sv
`timescale 1ns/1ps
module hyp_trap_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic [1:0] req_el,
  input logic       req_nonsecure,
  input logic       mode_e2h,
  input logic       mode_tge,
  input logic       el3_abort_route,
  input logic       nxt_trap,
  input logic       nxt_abort_el2,
  input logic       nxt_abort_el3,
  input logic       rsp_valid,
  input logic       rsp_trap_el2,
  input logic [5:0] rsp_syndrome,
  input logic       rsp_abort_el2,
  input logic       rsp_abort_el3
);

  // R1
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_trap_el2 && !rsp_abort_el2 && !rsp_abort_el3 && rsp_syndrome == 6'd0);

  // R6
  host_mode_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_e2h && mode_tge && req_op >= 3'd1 && req_op <= 3'd4) |=> !rsp_trap_el2);

  // R7
  syndrome_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap_el2 |-> (rsp_syndrome == 6'h03 || rsp_syndrome == 6'h04));

  // R7
  no_trap_no_syndrome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_trap_el2 |-> rsp_syndrome == 6'd0);

  // R8
  single_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_abort_el2, rsp_abort_el3, rsp_trap_el2}));

  // R8
  el3_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd7 && el3_abort_route) |=> rsp_abort_el3 && !rsp_abort_el2);

  // R8
  comb_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nxt_trap, nxt_abort_el2, nxt_abort_el3}));

  // R9
  secure_or_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (!req_nonsecure || req_el >= 2'd2 || req_op == 3'd0)) |=> !rsp_trap_el2);

endmodule

bind hyp_trap_decider hyp_trap_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_op          (req_op),
  .req_el          (req_el),
  .req_nonsecure   (req_nonsecure),
  .mode_e2h        (mode_e2h),
  .mode_tge        (mode_tge),
  .el3_abort_route (el3_abort_route),
  .nxt_trap        (nxt_trap),
  .nxt_abort_el2   (nxt_abort_el2),
  .nxt_abort_el3   (nxt_abort_el3),
  .rsp_valid       (rsp_valid),
  .rsp_trap_el2    (rsp_trap_el2),
  .rsp_syndrome    (rsp_syndrome),
  .rsp_abort_el2   (rsp_abort_el2),
  .rsp_abort_el3   (rsp_abort_el3)
);

// File: tb/hyp_trap_decider_tb.sv
`timescale 1ns/1ps
module hyp_trap_decider_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [1:0] req_el = '0;
  logic       req_nonsecure = 1'b0;
  logic       ctl_tlbis = 1'b0, ctl_pou = 1'b0, ctl_icab = 1'b0, ctl_idg4 = 1'b0;
  logic       ctl_errrec = 1'b0, ctl_abort_route = 1'b0;
  logic       mode_e2h = 1'b0, mode_tge = 1'b0, el3_abort_route = 1'b0;
  logic       rsp_valid, rsp_trap_el2, rsp_abort_el2, rsp_abort_el3;
  logic [5:0] rsp_syndrome;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hyp_trap_decider u_dut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_op (req_op),
    .req_el (req_el), .req_nonsecure (req_nonsecure),
    .ctl_tlbis (ctl_tlbis), .ctl_pou (ctl_pou), .ctl_icab (ctl_icab),
    .ctl_idg4 (ctl_idg4), .ctl_errrec (ctl_errrec),
    .ctl_abort_route (ctl_abort_route), .mode_e2h (mode_e2h),
    .mode_tge (mode_tge), .el3_abort_route (el3_abort_route),
    .rsp_valid (rsp_valid), .rsp_trap_el2 (rsp_trap_el2),
    .rsp_syndrome (rsp_syndrome), .rsp_abort_el2 (rsp_abort_el2),
    .rsp_abort_el3 (rsp_abort_el3)
  );

  // packed verdict: {valid, trap, syndrome[5:0], abort_el2, abort_el3}
  function automatic logic [9:0] reference(input logic [2:0] op, input logic [1:0] el,
      input logic ns, input logic [5:0] c, input logic e2h, input logic tge,
      input logic r3);
    logic host, el1, guest, t, a2, a3;
    logic [5:0] syn;
    host  = e2h && tge;
    el1   = ns && (el == 2'd1);
    guest = ns && (el < 2'd2);
    t = 1'b0; a2 = 1'b0; a3 = 1'b0;
    case (op)
      3'd1: t = c[5] && !host && el1;
      3'd2: t = c[4] && !host && guest;
      3'd3: t = c[3] && !host && el1;
      3'd4: t = c[2] && !host && guest;
      3'd5, 3'd6: t = c[1] && el1;
      3'd7: begin a3 = r3; a2 = !r3 && c[0] && guest; end
      default: ;
    endcase
    syn = !t ? 6'd0 : (op == 3'd6 ? 6'd4 : 6'd3);
    return {1'b1, t, syn, a2, a3};
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic e2h, input logic tge);
    if (e2h && tge && op >= 3'd1 && op <= 3'd4) return "R6";
    case (op)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5, 3'd6: return "R7";
      3'd7: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [9:0] observed();
    return {rsp_valid, rsp_trap_el2, rsp_syndrome, rsp_abort_el2, rsp_abort_el3};
  endfunction

  task automatic check(input string tag, input logic [9:0] exp);
    total++;
    if (observed() !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, observed(), exp);
    end
  endtask

  // called at a negedge; returns at the following negedge after checking
  task automatic run_op(input logic [2:0] op, input logic [1:0] el, input logic ns,
      input logic [5:0] c, input logic e2h, input logic tge, input logic r3);
    req_op = op; req_el = el; req_nonsecure = ns;
    {ctl_tlbis, ctl_pou, ctl_icab, ctl_idg4, ctl_errrec, ctl_abort_route} = c;
    mode_e2h = e2h; mode_tge = tge; el3_abort_route = r3;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag_of(op, e2h, tge), reference(op, el, ns, c, e2h, tge, r3));
  endtask

  task automatic idle_check();
    // R1: any leftover inputs, no strobe
    req_op = 3'd7; el3_abort_route = 1'b1; ctl_tlbis = 1'b1; req_el = 2'd1; req_nonsecure = 1'b1;
    req_op = 3'd1;
    @(negedge clk);
    check("R1", 10'd0);
  endtask

  initial begin
    void'($urandom(32'h5EED_2024));
    repeat (3) @(negedge clk);
    check("R1", 10'd0);           // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 10'd0);

    // directed corners
    run_op(3'd1, 2'd1, 1'b1, 6'b100000, 1'b0, 1'b0, 1'b0); // R2 trap
    run_op(3'd1, 2'd0, 1'b1, 6'b100000, 1'b0, 1'b0, 1'b0); // R2 EL0 no trap
    run_op(3'd2, 2'd0, 1'b1, 6'b010000, 1'b0, 1'b0, 1'b0); // R3 EL0 trap
    run_op(3'd3, 2'd1, 1'b1, 6'b001000, 1'b0, 1'b0, 1'b0); // R4
    run_op(3'd4, 2'd0, 1'b1, 6'b000100, 1'b0, 1'b0, 1'b0); // R5
    run_op(3'd4, 2'd1, 1'b1, 6'b111111, 1'b1, 1'b1, 1'b0); // R6 masked
    run_op(3'd5, 2'd1, 1'b1, 6'b111111, 1'b1, 1'b1, 1'b0); // R6/R7 not masked, 0x03
    run_op(3'd6, 2'd1, 1'b1, 6'b000010, 1'b0, 1'b0, 1'b0); // R7 0x04
    run_op(3'd6, 2'd1, 1'b0, 6'b000010, 1'b0, 1'b0, 1'b0); // R7 secure
    run_op(3'd7, 2'd0, 1'b1, 6'b000001, 1'b0, 1'b0, 1'b1); // R8 EL3 wins
    run_op(3'd7, 2'd1, 1'b1, 6'b000001, 1'b1, 1'b1, 1'b0); // R8 EL2 in host mode
    run_op(3'd7, 2'd2, 1'b1, 6'b000001, 1'b0, 1'b0, 1'b0); // R8 from EL2 stays
    run_op(3'd1, 2'd2, 1'b1, 6'b111111, 1'b0, 1'b0, 1'b0); // R9 EL2
    run_op(3'd0, 2'd1, 1'b1, 6'b111111, 1'b0, 1'b0, 1'b1); // R9 class 0
    run_op(3'd2, 2'd1, 1'b1, 6'b101111, 1'b0, 1'b0, 1'b0); // R9 control clear
    idle_check();

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] c;
      for (int b = 0; b < 6; b++) c[b] = ($urandom % 4) != 0;
      run_op(3'($urandom), 2'($urandom), ($urandom % 4) != 0, c,
             1'($urandom), 1'($urandom), ($urandom % 3) == 0);
      if (($urandom % 16) == 0) idle_check();
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule